// File: doc/BRIEF.md
# Memory-Mapped Serial Port Register Front-End

This block connects a word-addressed bus master to a byte-oriented serial channel. Software writes bytes into a transmit queue and reads bytes out of a receive queue through a small register window. Each direction has its own enable flag. A queue only exchanges bytes with the serial side while its flag is set. Bit 31 of the two data registers reports that the transmit queue is full or that the receive queue is empty.

Bus accesses complete in a single cycle. The read data and the error code are combinational on the request, and any queue push, pop or flag update happens at the next rising clock edge. On the serial side the block offers a valid/ready byte stream in each direction. Bit framing, baud timing and interrupt logic belong to the attached serialiser and are not part of this block.

Register map, byte offsets from the start of the window, all 32-bit words: 0x00 transmit data, 0x04 receive data, 0x08 transmit control, 0x0C receive control, 0x10 interrupt enable, 0x14 interrupt pending, 0x18 divisor.

Top module: `uart_mmio_frontend`

## Requirements
- R1: After reset both enable flags are 0. `ser_tx_valid` and `ser_rx_ready` are low, both control registers read 0, transmit data reads 0 and receive data reads 0x80000000.
- R2: A read of offset 0x00 returns 0x80000000 when the transmit queue holds DEPTH bytes, and 0 otherwise.
- R3: A write to offset 0x00 pushes `bus_wdata[7:0]` into the transmit queue with error code 0. When the queue is full, the byte is discarded and the error code is still 0.
- R4: A read of offset 0x04 removes the oldest received byte and returns it in bits 7:0, with bits 31:8 zero. When the queue is empty, the read returns 0x80000000 and the queue is unchanged.
- R5: Bit 0 of a write to offset 0x08 or 0x0C sets the transmit or receive enable flag. A read of the same offset returns the flag in bit 0, with all other bits 0.
- R6: Writes to offsets 0x04, 0x10, 0x14 and 0x18 return error code 0 and change nothing. Offsets 0x10 and 0x14 read 0, and offset 0x18 reads 1.
- R7: The error code `bus_err` is 0 for the seven listed offsets. It is 1 (misaligned) for any other offset below 0x1C, and 2 (access fault) for any offset at or above 0x1C. An access that returns an error reads 0 and has no side effect.
- R8: `ser_tx_valid` is high exactly when transmit is enabled and the transmit queue is not empty. The bytes leave in the order they were written, one byte per cycle in which `ser_tx_valid` and `ser_tx_ready` are both high.
- R9: `ser_rx_ready` is high exactly when receive is enabled and the receive queue is not full. A byte is stored in each cycle in which `ser_rx_valid` and `ser_rx_ready` are both high.
- R10: A push and a pop on the same queue in one cycle leave its fill count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_req | input | 1 | Bus access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during the request cycle |
| bus_err | output | 2 | 0 OK, 1 misaligned, 2 access fault |
| ser_tx_valid | output | 1 | Transmit byte available |
| ser_tx_data | output | 8 | Transmit byte |
| ser_tx_ready | input | 1 | Serialiser takes the transmit byte |
| ser_rx_valid | input | 1 | Serialiser offers a received byte |
| ser_rx_data | input | 8 | Received byte |
| ser_rx_ready | output | 1 | Block accepts the received byte |

## Verification
The assertions assume that the serialiser drives `ser_tx_ready` and `ser_rx_valid` to known values every cycle. They also assume that a bus access lasts exactly one request cycle, because a held read of receive data would pop again on each edge. The stimulus changes every input on the falling clock edge. It raises `bus_req` for a single cycle per access and pulses each serial handshake for one cycle only. The one exception is the test of a push and a pop in the same cycle, where a bus push and a serial take are deliberately lined up on one edge.

// File: rtl/uart_mmio_pkg.sv
// Package: shared constants and types for the serial port register front-end.
// Assumes byte offsets within a window whose last register sits at 0x18.
package uart_mmio_pkg;

    localparam int unsigned OFS_TXDATA = 'h00;
    localparam int unsigned OFS_RXDATA = 'h04;
    localparam int unsigned OFS_TXCTRL = 'h08;
    localparam int unsigned OFS_RXCTRL = 'h0C;
    localparam int unsigned OFS_IEN    = 'h10;
    localparam int unsigned OFS_IPEND  = 'h14;
    localparam int unsigned OFS_DIVR   = 'h18;
    localparam int unsigned WINDOW_END = 'h1C;

    localparam logic [31:0] FLAG_TOP   = 32'h8000_0000;
    localparam logic [31:0] DIV_FIXED  = 32'h0000_0001;

    typedef enum logic [1:0] {
        BUS_OK       = 2'd0,
        BUS_MISALIGN = 2'd1,
        BUS_FAULT    = 2'd2
    } bus_err_e;

    // One-hot selection of the register hit by a valid access.
    typedef struct packed {
        logic txdata;
        logic rxdata;
        logic txctrl;
        logic rxctrl;
        logic ien;
        logic ipend;
        logic divr;
    } reg_sel_t;

endpackage

// File: rtl/uart_byte_fifo.sv
// Module: circular byte queue with head, tail and fill count.
// Assumes DEPTH is a power of two. A push while full and a pop while empty are
// ignored. A push and a pop in the same cycle leave the count unchanged.
module uart_byte_fifo #(
    parameter int unsigned DEPTH  = 2048,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output logic              full,
    output logic              empty
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] store [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  fill;
    logic              do_push;
    logic              do_pop;

    // Qualify requests with the current occupancy.
    always_comb begin
        full    = (fill == CNT_MAX);
        empty   = (fill == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
    end

    // Storage array, written at the tail position.
    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wr_ptr] <= push_data;
        end
    end

    // Pointer and count update, wrapping at the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            end
            if (do_push && !do_pop) begin
                fill <= fill + 1'b1;
            end else if (do_pop && !do_push) begin
                fill <= fill - 1'b1;
            end
        end
    end

    // Oldest byte, presented combinationally.
    always_comb begin
        head_data = store[rd_ptr];
    end

endmodule

// File: rtl/uart_reg_decode.sv
// Module: address decoder for the register window.
// Assumes byte offsets. Listed word offsets give a one-hot select. Other offsets
// below the window end are misaligned, and offsets past it are access faults.
// The selects and the error code are only meaningful while req is high.
module uart_reg_decode
    import uart_mmio_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel,
    output bus_err_e          err
);
    localparam logic [ADDR_W-1:0] A_END = ADDR_W'(WINDOW_END);

    logic in_window;
    logic listed;

    // Match the address against each register slot.
    always_comb begin
        sel        = '0;
        in_window  = (addr < A_END);
        sel.txdata = (addr == ADDR_W'(OFS_TXDATA));
        sel.rxdata = (addr == ADDR_W'(OFS_RXDATA));
        sel.txctrl = (addr == ADDR_W'(OFS_TXCTRL));
        sel.rxctrl = (addr == ADDR_W'(OFS_RXCTRL));
        sel.ien    = (addr == ADDR_W'(OFS_IEN));
        sel.ipend  = (addr == ADDR_W'(OFS_IPEND));
        sel.divr   = (addr == ADDR_W'(OFS_DIVR));
        listed     = |sel;
        if (!req) begin
            sel = '0;
        end
    end

    // Classify the access outcome.
    always_comb begin
        if (!req || listed) begin
            err = BUS_OK;
        end else if (in_window) begin
            err = BUS_MISALIGN;
        end else begin
            err = BUS_FAULT;
        end
    end

endmodule

// File: rtl/uart_ctrl_regs.sv
// Module: holds the per-direction enable flags.
// Assumes its write strobes are already qualified by a valid, error-free access.
// Both flags reset to 0, so no serial traffic flows until software enables it.
module uart_ctrl_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_tx,
    input  logic wr_rx,
    input  logic wbit,
    output logic tx_en,
    output logic rx_en
);
    // Capture bit 0 of the write data into the addressed flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en <= 1'b0;
            rx_en <= 1'b0;
        end else begin
            if (wr_tx) begin
                tx_en <= wbit;
            end
            if (wr_rx) begin
                rx_en <= wbit;
            end
        end
    end

endmodule

// File: rtl/uart_mmio_frontend.sv
// Module: top of the register front-end. It joins the decoder, the enable flags
// and the two byte queues to the bus port and the serial handshakes.
// Assumes a bus access is a one-cycle request. The read data and the error code
// are combinational, and every side effect lands on the following rising edge.
module uart_mmio_frontend
    import uart_mmio_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DEPTH  = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [1:0]        bus_err,
    output logic              ser_tx_valid,
    output logic [7:0]        ser_tx_data,
    input  logic              ser_tx_ready,
    input  logic              ser_rx_valid,
    input  logic [7:0]        ser_rx_data,
    output logic              ser_rx_ready
);
    reg_sel_t sel;
    bus_err_e dec_err;
    logic     tx_en;
    logic     rx_en;
    logic     tx_full;
    logic     tx_empty;
    logic     rx_full;
    logic     rx_empty;
    logic [7:0] rx_head;
    logic     tx_push;
    logic     tx_pop;
    logic     rx_push;
    logic     rx_pop;
    logic     wr_acc;
    logic     rd_acc;

    uart_reg_decode #(
        .ADDR_W (ADDR_W)
    ) u_dec (
        .req  (bus_req),
        .addr (bus_addr),
        .sel  (sel),
        .err  (dec_err)
    );

    // Access qualifiers. A listed select already implies no error.
    always_comb begin
        wr_acc = bus_req && bus_we;
        rd_acc = bus_req && !bus_we;
    end

    uart_ctrl_regs u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_tx (wr_acc && sel.txctrl),
        .wr_rx (wr_acc && sel.rxctrl),
        .wbit  (bus_wdata[0]),
        .tx_en (tx_en),
        .rx_en (rx_en)
    );

    // Queue strobes from the bus side and the serial side.
    always_comb begin
        tx_push      = wr_acc && sel.txdata;
        ser_tx_valid = tx_en && !tx_empty;
        tx_pop       = ser_tx_valid && ser_tx_ready;
        ser_rx_ready = rx_en && !rx_full;
        rx_push      = ser_rx_valid && ser_rx_ready;
        rx_pop       = rd_acc && sel.rxdata;
    end

    uart_byte_fifo #(
        .DEPTH  (DEPTH),
        .DATA_W (8)
    ) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (tx_push),
        .push_data (bus_wdata[7:0]),
        .pop       (tx_pop),
        .head_data (ser_tx_data),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    uart_byte_fifo #(
        .DEPTH  (DEPTH),
        .DATA_W (8)
    ) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_push),
        .push_data (ser_rx_data),
        .pop       (rx_pop),
        .head_data (rx_head),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    // Read data multiplexer. Writes and errored accesses read 0.
    always_comb begin
        bus_rdata = '0;
        if (rd_acc) begin
            unique case (1'b1)
                sel.txdata: bus_rdata = tx_full ? FLAG_TOP : '0;
                sel.rxdata: bus_rdata = rx_empty ? FLAG_TOP : {24'd0, rx_head};
                sel.txctrl: bus_rdata = {31'd0, tx_en};
                sel.rxctrl: bus_rdata = {31'd0, rx_en};
                sel.divr:   bus_rdata = DIV_FIXED;
                default:    bus_rdata = '0;
            endcase
        end
    end

    // Error code to the bus.
    always_comb begin
        bus_err = dec_err;
    end

endmodule

// File: rtl/uart_mmio_frontend_chk.sv
// Module: property checker attached to the front-end through a bind statement.
// Assumes known serial handshake inputs and one-cycle bus requests.
module uart_mmio_frontend_chk #(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic [1:0]        bus_err,
    input logic              ser_tx_valid,
    input logic [7:0]        ser_tx_data,
    input logic              ser_tx_ready,
    input logic              ser_rx_ready
);
    logic rd_hit;
    logic ctrl_wr;
    logic tx_wr;

    // Shorthand terms for the properties below.
    always_comb begin
        rd_hit  = bus_req && !bus_we;
        ctrl_wr = bus_req && bus_we && (bus_addr == ADDR_W'('h08));
        tx_wr   = bus_req && bus_we && (bus_addr == ADDR_W'('h00));
    end

    // R1: the serial side is quiet in the first cycle after reset.
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!ser_tx_valid && !ser_rx_ready));

    // R2: a transmit data read carries nothing but the full flag.
    a_r2_txdata_flag_only: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && bus_addr == ADDR_W'('h00)) |-> (bus_rdata[30:0] == '0));

    // R4: an empty receive read has no byte in it.
    a_r4_rx_empty_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && bus_addr == ADDR_W'('h04) && bus_rdata[31]) |-> (bus_rdata[30:0] == '0));

    // R4: a receive data read never sets bits 30:8.
    a_r4_rx_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && bus_addr == ADDR_W'('h04)) |-> (bus_rdata[30:8] == '0));

    // R6: the divisor always reads 1.
    a_r6_div_one: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && bus_addr == ADDR_W'('h18)) |-> (bus_rdata == 32'd1));

    // R7: only the three defined error codes appear.
    a_r7_err_legal: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err != 2'd3);

    // R7: an errored access reads 0.
    a_r7_err_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_err != 2'd0) |-> (bus_rdata == '0));

    // R8: an untaken transmit byte stays offered and unchanged.
    a_r8_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_tx_valid && !ser_tx_ready && !ctrl_wr) |=> (ser_tx_valid && $stable(ser_tx_data)));

    // R8: pushing into an enabled, non-empty queue keeps a byte on offer.
    a_r8_tx_stays_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_tx_valid && tx_wr && !ctrl_wr) |=> ser_tx_valid);

endmodule

bind uart_mmio_frontend uart_mmio_frontend_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_req      (bus_req),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_rdata    (bus_rdata),
    .bus_err      (bus_err),
    .ser_tx_valid (ser_tx_valid),
    .ser_tx_data  (ser_tx_data),
    .ser_tx_ready (ser_tx_ready),
    .ser_rx_ready (ser_rx_ready)
);

// File: tb/sim_uart_mmio_frontend.sv
// Bench: directed scenarios, one task each, with checks inside every task.
module sim_uart_mmio_frontend;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 12;
    localparam int QDEPTH     = 8;
    localparam int WATCHDOG   = 50000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_req = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [1:0]    bus_err;
    logic          ser_tx_valid;
    logic [7:0]    ser_tx_data;
    logic          ser_tx_ready = 1'b0;
    logic          ser_rx_valid = 1'b0;
    logic [7:0]    ser_rx_data = '0;
    logic          ser_rx_ready;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    uart_mmio_frontend #(.ADDR_W(AW), .DEPTH(QDEPTH)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_req      (bus_req),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .bus_err      (bus_err),
        .ser_tx_valid (ser_tx_valid),
        .ser_tx_data  (ser_tx_data),
        .ser_tx_ready (ser_tx_ready),
        .ser_rx_valid (ser_rx_valid),
        .ser_rx_data  (ser_rx_data),
        .ser_rx_ready (ser_rx_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One-cycle bus write; returns the error code.
    task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d, output logic [1:0] e);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        #1 e = bus_err;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    // One-cycle bus read; returns data and error code.
    task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d, output logic [1:0] e);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 begin d = bus_rdata; e = bus_err; end
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    // Take one transmit byte and compare it.
    task automatic take_tx(input string req, input logic [7:0] exp);
        @(negedge clk);
        check(req, {31'd0, ser_tx_valid}, 32'd1);
        check(req, {24'd0, ser_tx_data}, {24'd0, exp});
        ser_tx_ready = 1'b1;
        @(negedge clk);
        ser_tx_ready = 1'b0;
    endtask

    // Offer one receive byte; returns whether it was accepted.
    task automatic give_rx(input logic [7:0] b, output logic acc);
        @(negedge clk);
        ser_rx_valid = 1'b1; ser_rx_data = b;
        #1 acc = ser_rx_ready;
        @(negedge clk);
        ser_rx_valid = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d; logic [1:0] e;
        @(negedge clk);
        check("R1 tx_valid", {31'd0, ser_tx_valid}, 32'd0);
        check("R1 rx_ready", {31'd0, ser_rx_ready}, 32'd0);
        bus_rd('h08, d, e); check("R1 txctrl", d, 32'd0);
        bus_rd('h0C, d, e); check("R1 rxctrl", d, 32'd0);
        bus_rd('h00, d, e); check("R1 R2 txdata", d, 32'd0);
        bus_rd('h04, d, e); check("R1 R4 rxdata empty", d, 32'h8000_0000);
    endtask

    task automatic t_tx_order;
        logic [31:0] d; logic [1:0] e;
        bus_wr('h00, 32'h0000_01A5, e); check("R3 err", {30'd0, e}, 32'd0);
        bus_wr('h00, 32'hFFFF_FF3C, e);
        bus_wr('h00, 32'h0000_007F, e);
        @(negedge clk); check("R8 disabled tx_valid", {31'd0, ser_tx_valid}, 32'd0);
        bus_wr('h08, 32'd1, e);
        bus_rd('h08, d, e); check("R5 txctrl readback", d, 32'd1);
        take_tx("R8 R3 byte0", 8'hA5);
        take_tx("R8 R3 byte1", 8'h3C);
        take_tx("R8 R3 byte2", 8'h7F);
        @(negedge clk); check("R8 empty tx_valid", {31'd0, ser_tx_valid}, 32'd0);
        bus_wr('h08, 32'd0, e);
    endtask

    task automatic t_tx_full;
        logic [31:0] d; logic [1:0] e;
        for (int i = 0; i < QDEPTH; i++) bus_wr('h00, 32'(8'h10 + i), e);
        bus_rd('h00, d, e); check("R2 full flag", d, 32'h8000_0000);
        bus_wr('h00, 32'h0000_00EE, e); check("R3 drop no error", {30'd0, e}, 32'd0);
        bus_wr('h08, 32'd1, e);
        for (int i = 0; i < QDEPTH; i++) take_tx("R3 R8 drain", 8'(8'h10 + i));
        @(negedge clk); check("R3 dropped byte absent", {31'd0, ser_tx_valid}, 32'd0);
        bus_wr('h08, 32'd0, e);
        bus_rd('h00, d, e); check("R2 not full", d, 32'd0);
    endtask

    task automatic t_rx;
        logic [31:0] d; logic [1:0] e; logic acc;
        give_rx(8'h99, acc); check("R9 disabled refuses", {31'd0, acc}, 32'd0);
        bus_rd('h04, d, e); check("R9 nothing stored", d, 32'h8000_0000);
        bus_wr('h0C, 32'hFFFF_FFFF, e);
        bus_rd('h0C, d, e); check("R5 rxctrl readback", d, 32'd1);
        give_rx(8'h11, acc); check("R9 accept", {31'd0, acc}, 32'd1);
        give_rx(8'hF2, acc);
        bus_rd('h04, d, e); check("R4 pop first", d, 32'h0000_0011);
        bus_rd('h04, d, e); check("R4 pop second zero-ext", d, 32'h0000_00F2);
        bus_rd('h04, d, e); check("R4 empty", d, 32'h8000_0000);
        for (int i = 0; i < QDEPTH; i++) give_rx(8'(8'h60 + i), acc);
        @(negedge clk); check("R9 full refuses", {31'd0, ser_rx_ready}, 32'd0);
        for (int i = 0; i < QDEPTH; i++) begin
            bus_rd('h04, d, e); check("R4 R9 drain", d, 32'(8'h60 + i));
        end
        bus_wr('h0C, 32'd0, e);
        bus_rd('h0C, d, e); check("R5 rxctrl cleared", d, 32'd0);
    endtask

    task automatic t_ignored;
        logic [31:0] d; logic [1:0] e; logic acc;
        bus_wr('h0C, 32'd1, e);
        give_rx(8'h5A, acc);
        bus_wr('h04, 32'h0000_0099, e); check("R6 rxdata write ok", {30'd0, e}, 32'd0);
        bus_wr('h10, 32'hFFFF_FFFF, e); check("R6 ien write ok", {30'd0, e}, 32'd0);
        bus_wr('h14, 32'hFFFF_FFFF, e);
        bus_wr('h18, 32'h0000_0055, e);
        bus_rd('h10, d, e); check("R6 ien reads 0", d, 32'd0);
        bus_rd('h14, d, e); check("R6 ipend reads 0", d, 32'd0);
        bus_rd('h18, d, e); check("R6 div reads 1", d, 32'd1);
        bus_rd('h04, d, e); check("R6 rx queue untouched", d, 32'h0000_005A);
        bus_rd('h04, d, e); check("R6 no extra byte", d, 32'h8000_0000);
        bus_wr('h0C, 32'd0, e);
    endtask

    task automatic t_errors;
        logic [31:0] d; logic [1:0] e; logic acc;
        bus_rd('h02, d, e); check("R7 misaligned", {30'd0, e}, 32'd1);
        bus_rd('h1B, d, e); check("R7 misaligned top", {30'd0, e}, 32'd1);
        bus_rd('h1C, d, e); check("R7 fault edge", {30'd0, e}, 32'd2);
        bus_rd('h40, d, e); check("R7 fault far", {30'd0, e}, 32'd2);
        bus_wr('h01, 32'h0000_0077, e); check("R7 write misaligned", {30'd0, e}, 32'd1);
        bus_wr('h09, 32'd1, e);
        bus_rd('h08, d, e); check("R7 ctrl not hit", d, 32'd0);
        bus_wr('h08, 32'd1, e);
        @(negedge clk); check("R7 no push on error", {31'd0, ser_tx_valid}, 32'd0);
        bus_wr('h08, 32'd0, e);
        bus_wr('h0C, 32'd1, e);
        give_rx(8'h3D, acc);
        bus_rd('h05, d, e); check("R7 errored read data", d, 32'd0);
        bus_rd('h04, d, e); check("R7 no pop on error", d, 32'h0000_003D);
        bus_wr('h0C, 32'd0, e);
    endtask

    task automatic t_concurrent;
        logic [31:0] d; logic [1:0] e;
        for (int i = 0; i < QDEPTH - 1; i++) bus_wr('h00, 32'(8'h40 + i), e);
        bus_wr('h08, 32'd1, e);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 'h00; bus_wdata = 32'h80;
        ser_tx_ready = 1'b1;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; ser_tx_ready = 1'b0;
        bus_wr('h08, 32'd0, e);
        bus_rd('h00, d, e); check("R10 count kept", d, 32'd0);
        bus_wr('h00, 32'h81, e);
        bus_rd('h00, d, e); check("R10 full after one more", d, 32'h8000_0000);
        bus_wr('h08, 32'd1, e);
        for (int i = 1; i < QDEPTH - 1; i++) take_tx("R10 order", 8'(8'h40 + i));
        take_tx("R10 pushed byte", 8'h80);
        take_tx("R10 last byte", 8'h81);
        bus_wr('h08, 32'd0, e);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_tx_order();
        t_tx_full();
        t_rx();
        t_ignored();
        t_errors();
        t_concurrent();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule